// File: doc/BRIEF.md
# Multi-Rail Reset Generator with Manual Reset

This block turns the health of several supply rails into one active-low system reset. For every rail it takes a comparator result (rail above threshold), an enable and the rail's own power-good output. It also takes an active-low manual-reset request and an undervoltage-lockout flag. While any rail is low, any enable is low, any power-good is low, the manual request is active or lockout is raised, the reset output is held low.

Once all of those conditions are clear at the same time, a timer runs. The reset output is released only when the timer expires. Any new fault while the timer runs clears it, and the full period starts again once every condition is clear. The period comes from one of three modes: a long fixed default, a count supplied on a port, or a short internal delay. The manual-reset input and the enables pass through saturating-counter glitch filters. The filter threshold is derived from the clock period and the shortest pulse that must be rejected. Undervoltage lockout bypasses all registers and drives the output low in the same cycle.

Top module: `mrg_reset_gen`

## Requirements
- R1: While the synchronous reset `rst_n` is low, `rst_out_n` is low.
- R2: If any bit of `rail_ok` is low at a clock edge, `rst_out_n` is low after that edge.
- R3: If any bit of `rail_pg` is low at a clock edge, `rst_out_n` is low after that edge.
- R4: An enable that is low for FILT consecutive edges forces `rst_out_n` low after edge FILT+1. A low pulse shorter than FILT edges has no effect. FILT = ceil(GLITCH_PS / CLK_PERIOD_PS), minimum 1.
- R5: `mr_n` held low for FILT consecutive edges forces `rst_out_n` low after edge FILT+1, and the output stays low while it is held. A shorter low pulse has no effect. After `mr_n` returns high, the output rises FILT+L edges later.
- R6: Once every release condition holds, `rst_out_n` rises exactly L clock edges later, counting the first edge at which all conditions hold.
- R7: With `tmo_mode` = 2'b00, L = FIXED_CYCLES.
- R8: With `tmo_mode` = 2'b01, L = `tmo_prog`, and a value of 0 is treated as 1.
- R9: With `tmo_mode` = 2'b10 or 2'b11, L = SHORT_CYCLES.
- R10: A fault while the timer runs clears it. Release then takes a full L edges from the moment all conditions hold again.
- R11: `uvlo` high drives `rst_out_n` low in the same cycle, without waiting for a clock edge. Lockout also clears the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rail_ok | input | N_RAILS | Per-rail comparator: 1 = rail above threshold |
| rail_en | input | N_RAILS | Per-rail enable, active high, glitch filtered |
| rail_pg | input | N_RAILS | Per-rail power-good output state |
| mr_n | input | 1 | Manual reset request, active low, glitch filtered |
| uvlo | input | 1 | Undervoltage lockout, active high |
| tmo_mode | input | 2 | Timeout select: 00 fixed, 01 programmable, 1x short |
| tmo_prog | input | PROG_W | Programmable timeout in clock cycles |
| rst_out_n | output | 1 | System reset, active low |

## Verification
The assertions assume that `rail_ok`, `rail_pg`, `rail_en`, `mr_n` and `uvlo` are already synchronous to `clk`. They also assume that `tmo_mode` and `tmo_prog` change only while a fault holds the output low, so the timer length is constant for the whole of one release. The stimulus changes every input on the falling clock edge. It changes the mode and the programmed count only in the same cycle that it injects a fault. The manual-reset and enable pulses are sized against FILT from both sides, one edge short of it and well beyond it.

// File: rtl/mrg_pkg.sv
// Package: shared types and helpers for the multi-rail reset generator.
// Assumes callers pass positive periods.
package mrg_pkg;

    // Timeout source selected by the mode input
    typedef enum logic [1:0] {
        TMO_FIXED     = 2'b00,
        TMO_PROG      = 2'b01,
        TMO_SHORT     = 2'b10,
        TMO_SHORT_ALT = 2'b11
    } tmo_mode_e;

    // Number of clock cycles covering a span given in picoseconds (rounded up, at least 1)
    function automatic int cycles_for(input int span_ps, input int period_ps);
        int c;
        c = (span_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/mrg_glitch_filter.sv
// Module: mrg_glitch_filter
// Single-bit glitch filter built on a saturating counter. The filtered output
// follows the input only after the input has differed from it for FILT
// consecutive clock edges. Any return to agreement clears the counter.
// Assumes the input is already synchronous to clk.
module mrg_glitch_filter #(
    parameter int FILT_CYCLES = 4,
    parameter bit INIT_VALUE  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          val_q;

    // Count edges of disagreement and flip the output when the run completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            val_q <= INIT_VALUE;
        end else if (din == val_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            val_q <= din;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/mrg_fault_merge.sv
// Module: mrg_fault_merge
// Combinational merge of every reset cause into one fault flag. A fault is
// raised while any rail is low, any enable is low, any power-good is low, the
// manual request is active or lockout is set. Assumes filtered inputs.
module mrg_fault_merge #(
    parameter int N_RAILS = 4
) (
    input  logic [N_RAILS-1:0] rail_ok,
    input  logic [N_RAILS-1:0] en_filt,
    input  logic [N_RAILS-1:0] rail_pg,
    input  logic               mr_filt_n,
    input  logic               uvlo,
    output logic               fault
);
    // OR of all hold conditions
    always_comb begin
        fault = uvlo | ~mr_filt_n | ~(&rail_ok) | ~(&en_filt) | ~(&rail_pg);
    end

endmodule

// File: rtl/mrg_timeout_ctr.sv
// Module: mrg_timeout_ctr
// Release timer. While hold is high it keeps released low and clears the
// count. Otherwise it counts edges and sets released once limit edges have
// passed, clearing the count at that moment. Assumes limit >= 1.
module mrg_timeout_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             released
);
    logic [CNT_W-1:0] cnt_q;
    logic             rel_q;
    logic [CNT_W-1:0] last;

    // Final count value before release
    always_comb begin
        last = limit - 1'b1;
    end

    // Timer and release flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (hold) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (!rel_q) begin
            if (cnt_q == last) begin
                cnt_q <= '0;
                rel_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign released = rel_q;

endmodule

// File: rtl/mrg_reset_gen.sv
// Module: mrg_reset_gen (top)
// Multi-rail reset generator. Filters the manual request and enables, merges
// all causes into a fault, runs the release timer in the selected mode and
// drives the active-low system reset. Lockout bypasses the registers.
// Assumes all inputs are synchronous to clk and that the mode and programmed
// count are stable while the timer runs.
module mrg_reset_gen #(
    parameter int N_RAILS       = 4,
    parameter int PROG_W        = 16,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int GLITCH_PS     = 280000,
    parameter int FIXED_CYCLES  = 23750000,
    parameter int SHORT_CYCLES  = 4375
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_ok,
    input  logic [N_RAILS-1:0] rail_en,
    input  logic [N_RAILS-1:0] rail_pg,
    input  logic               mr_n,
    input  logic               uvlo,
    input  logic [1:0]         tmo_mode,
    input  logic [PROG_W-1:0]  tmo_prog,
    output logic               rst_out_n
);
    import mrg_pkg::*;

    localparam int FILT_CYCLES = cycles_for(GLITCH_PS, CLK_PERIOD_PS);
    localparam int FIX_W       = $clog2(FIXED_CYCLES + 1);
    localparam int SHR_W       = $clog2(SHORT_CYCLES + 1);
    localparam int W_A         = (FIX_W > PROG_W) ? FIX_W : PROG_W;
    localparam int CNT_W       = (W_A > SHR_W) ? W_A : SHR_W;

    logic [N_RAILS-1:0] en_filt;
    logic               mr_filt_n;
    logic               fault;
    logic               released;
    logic [CNT_W-1:0]   limit;
    tmo_mode_e          mode;

    // One filter per enable; enables start low until they prove stable
    for (genvar g = 0; g < N_RAILS; g++) begin : g_en_filt
        mrg_glitch_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .INIT_VALUE (1'b0)
        ) u_en_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (rail_en[g]),
            .dout (en_filt[g])
        );
    end

    mrg_glitch_filter #(
        .FILT_CYCLES(FILT_CYCLES),
        .INIT_VALUE (1'b1)
    ) u_mr_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (mr_n),
        .dout (mr_filt_n)
    );

    mrg_fault_merge #(
        .N_RAILS(N_RAILS)
    ) u_merge (
        .rail_ok  (rail_ok),
        .en_filt  (en_filt),
        .rail_pg  (rail_pg),
        .mr_filt_n(mr_filt_n),
        .uvlo     (uvlo),
        .fault    (fault)
    );

    // Pick the timeout length for the selected mode
    always_comb begin
        mode = tmo_mode_e'(tmo_mode);
        unique case (mode)
            TMO_FIXED: limit = CNT_W'(FIXED_CYCLES);
            TMO_PROG:  limit = (tmo_prog == '0) ? CNT_W'(1) : CNT_W'(tmo_prog);
            default:   limit = CNT_W'(SHORT_CYCLES);
        endcase
    end

    mrg_timeout_ctr #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (fault),
        .limit   (limit),
        .released(released)
    );

    // Lockout acts without a clock edge
    assign rst_out_n = released & ~uvlo;

endmodule

// File: rtl/mrg_reset_gen_chk.sv
// Module: mrg_reset_gen_chk
// Assertion checker bound to mrg_reset_gen. It relates the input ports to the
// reset output over time. Assumes inputs are synchronous to clk.
module mrg_reset_gen_chk #(
    parameter int N_RAILS       = 4,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int GLITCH_PS     = 280000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RAILS-1:0] rail_ok,
    input logic [N_RAILS-1:0] rail_pg,
    input logic               mr_n,
    input logic               uvlo,
    input logic               rst_out_n
);
    import mrg_pkg::*;

    localparam int FILT = cycles_for(GLITCH_PS, CLK_PERIOD_PS);
    localparam int RW   = $clog2(FILT + 1);
    localparam logic [RW-1:0] FULL = RW'(FILT);

    logic [RW-1:0] mr_run_q;

    // Saturating count of consecutive low samples of the manual request
    always_ff @(posedge clk) begin
        if (!rst_n || mr_n) begin
            mr_run_q <= '0;
        end else if (mr_run_q != FULL) begin
            mr_run_q <= mr_run_q + 1'b1;
        end
    end

    // R2
    rail_low_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&rail_ok) |=> !rst_out_n);

    // R3
    pg_low_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&rail_pg) |=> !rst_out_n);

    // R5
    mr_held_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_run_q == FULL) |=> !rst_out_n);

    // R11
    uvlo_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> !rst_out_n);

    // R6
    rise_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(&rail_ok) && $past(&rail_pg) && !$past(uvlo)));

endmodule

bind mrg_reset_gen mrg_reset_gen_chk #(
    .N_RAILS      (N_RAILS),
    .CLK_PERIOD_PS(CLK_PERIOD_PS),
    .GLITCH_PS    (GLITCH_PS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_ok  (rail_ok),
    .rail_pg  (rail_pg),
    .mr_n     (mr_n),
    .uvlo     (uvlo),
    .rst_out_n(rst_out_n)
);

// File: tb/mrg_reset_gen_bench.sv
module mrg_reset_gen_bench;
    localparam int N      = 4;
    localparam int PW     = 16;
    localparam int FILT   = 4;
    localparam int FIXED  = 40;
    localparam int SHORT  = 5;
    localparam int NV     = 6;

    // Vector table: mode, programmed count, expected length, fault kind (0 rail, 1 power-good)
    localparam int V_MODE [NV] = '{0, 1, 1, 2, 3, 1};
    localparam int V_PROG [NV] = '{0, 10, 0, 0, 0, 3};
    localparam int V_LEN  [NV] = '{FIXED, 10, 1, SHORT, SHORT, 3};
    localparam int V_KIND [NV] = '{0, 1, 0, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  rail_ok, rail_en, rail_pg;
    logic          mr_n, uvlo;
    logic [1:0]    tmo_mode;
    logic [PW-1:0] tmo_prog;
    logic          rst_out_n;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    mrg_reset_gen #(
        .N_RAILS(N), .PROG_W(PW), .CLK_PERIOD_PS(8000), .GLITCH_PS(8000 * FILT),
        .FIXED_CYCLES(FIXED), .SHORT_CYCLES(SHORT)
    ) u_mrg_reset_gen (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .rail_en(rail_en),
        .rail_pg(rail_pg), .mr_n(mr_n), .uvlo(uvlo), .tmo_mode(tmo_mode),
        .tmo_prog(tmo_prog), .rst_out_n(rst_out_n)
    );

    task automatic chk(input logic exp, input string req);
        checks++;
        if (rst_out_n !== exp) begin
            failures++;
            $display("FAIL %s: rst_out_n actual=%b expected=%b at %0t", req, rst_out_n, exp, $time);
        end
    endtask

    // Starting at a falling edge: low after len-1 edges, high after len
    task automatic expect_rise(input int len, input string req);
        repeat (len - 1) @(negedge clk);
        chk(1'b0, req);
        @(negedge clk);
        chk(1'b1, req);
    endtask

    initial begin
        rst_n = 1'b0; rail_ok = '1; rail_en = '1; rail_pg = '1;
        mr_n = 1'b1; uvlo = 1'b0; tmo_mode = 2'b10; tmo_prog = '0;
        // R1: output low throughout reset
        repeat (3) begin @(negedge clk); chk(1'b0, "R1"); end
        rst_n = 1'b1;
        // R4 R9: enables need FILT edges, then the short timeout
        expect_rise(FILT + SHORT, "R9");

        // Table walk: R2 R3 fault, then R6 R7 R8 R9 lengths
        for (int i = 0; i < NV; i++) begin
            tmo_mode = V_MODE[i][1:0];
            tmo_prog = V_PROG[i][PW-1:0];
            if (V_KIND[i] == 0) rail_ok[i % N] = 1'b0;
            else rail_pg[i % N] = 1'b0;
            @(negedge clk);
            chk(1'b0, (V_KIND[i] == 0) ? "R2" : "R3");
            rail_ok = '1; rail_pg = '1;
            expect_rise(V_LEN[i], "R6");
        end

        tmo_mode = 2'b01; tmo_prog = 16'd10;
        // R10: fault mid-timeout restarts the full count
        rail_ok[1] = 1'b0; @(negedge clk); rail_ok[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk(1'b0, "R10");
        rail_pg[3] = 1'b0; @(negedge clk); chk(1'b0, "R10"); rail_pg[3] = 1'b1;
        expect_rise(10, "R10");

        // R11: lockout pulls the output low before any edge
        uvlo = 1'b1; #1; chk(1'b0, "R11");
        @(negedge clk); uvlo = 1'b0;
        expect_rise(10, "R11");

        // R5: short manual pulse rejected
        mr_n = 1'b0; repeat (FILT - 1) @(negedge clk); mr_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(1'b1, "R5");
        // R5: long manual pulse honoured, held, then timed release
        mr_n = 1'b0; repeat (FILT) @(negedge clk);
        chk(1'b1, "R5");
        @(negedge clk); chk(1'b0, "R5");
        repeat (20) @(negedge clk); chk(1'b0, "R5");
        mr_n = 1'b1;
        expect_rise(FILT + 10, "R5");

        // R4: short enable drop rejected
        rail_en[2] = 1'b0; repeat (FILT - 1) @(negedge clk); rail_en[2] = 1'b1;
        repeat (8) @(negedge clk);
        chk(1'b1, "R4");
        // R4: long enable drop honoured
        rail_en[2] = 1'b0; repeat (FILT) @(negedge clk);
        chk(1'b1, "R4");
        @(negedge clk); chk(1'b0, "R4");
        rail_en[2] = 1'b1;
        expect_rise(FILT + 10, "R4");

        // R7: fixed mode after a late mode change under fault
        tmo_mode = 2'b00; uvlo = 1'b1; @(negedge clk); uvlo = 1'b0;
        expect_rise(FIXED, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule